// File: doc/BRIEF.md
# DRAM Refresh Interval Timer and Strobe Sequencer

This block keeps dynamic memory alive. It counts clock cycles, and when a programmed interval runs out it raises a refresh request to the access sequencer. Once the sequencer grants the request, the block runs one refresh cycle. For asynchronous DRAM this is a CAS-before-RAS cycle: the CAS strobe goes up first, RAS follows after the setup time, both stay up for the hold time, and then both drop. For SDRAM the block issues a single-cycle refresh command and then stays busy for the row cycle time. In both modes the cycle ends with a one-cycle done pulse.

Software sets the configuration through static inputs: an enable, an 11-bit count value, a CAS setup bit, a 3-bit hold/row-cycle code and a mode select. The interval is (2^11 − count + 1) cycles. A new count value is picked up at the next reload of the interval counter. An expiry that happens while a request is already waiting is merged into that request.

Top module: `dram_refresh_ctl`

## Requirements
- R1: While `cfg_enable` is 0, `ref_req` stays 0 and the interval counter is held reset. No request appears until `cfg_enable` has been 1 for a full interval.
- R2: Let P = 2048 − `cfg_count` + 1, so `cfg_count` = 0 gives 2049. When `cfg_enable` is first sampled 1 at clock edge k, `ref_req` rises after edge k+P.
- R3: While enabled, the counter reloads at every expiry, so expiries come every P cycles. A changed `cfg_count` takes effect at the next reload.
- R4: An expiry while `ref_req` is already 1 does not queue a second request. One grant serves all expiries merged into the pending request.
- R5: A grant is accepted only when `ref_req` is 1 and no refresh cycle is running. `ref_req` clears at the edge that accepts the grant, unless an expiry happens at that same edge. `ref_grant` has no effect at any other time.
- R6: In DRAM mode (`cfg_sdram` = 0), `ref_cas` is asserted alone for S cycles after acceptance, where S = 1 if `cfg_setup` = 0 and S = 2 if `cfg_setup` = 1. Then `ref_cas` and `ref_ras` are both asserted for H cycles.
- R7: In DRAM mode, hold codes 0 to 4 give H = code + 1. Codes 5, 6 and 7 are clamped to H = 5.
- R8: After the strobe phase (DRAM) or the busy phase (SDRAM), `ref_done` is 1 for exactly one cycle with all strobes low. The block then returns to idle.
- R9: In SDRAM mode, `sd_ref_cmd` pulses for one cycle after acceptance, followed by T busy cycles, where T = code + 1 for codes 0 to 5 and codes 6 and 7 are clamped to 6. `cfg_setup` is ignored, and `ref_cas` and `ref_ras` stay 0.
- R10: Clearing `cfg_enable` drops a pending request at the next edge. A refresh cycle already running still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Refresh generation on (1) or off (0) |
| cfg_count | input | 11 | Interval count value; interval is 2^11 − value + 1 cycles |
| cfg_setup | input | 1 | CAS setup: 0 gives 1 cycle, 1 gives 2 cycles (DRAM mode only) |
| cfg_hold | input | 3 | CAS hold code (DRAM) or row cycle code (SDRAM) |
| cfg_sdram | input | 1 | Mode select: 0 asynchronous DRAM, 1 SDRAM |
| ref_grant | input | 1 | Grant from the access sequencer |
| ref_req | output | 1 | Pending refresh request |
| ref_cas | output | 1 | CAS refresh strobe to all banks, active high |
| ref_ras | output | 1 | RAS refresh strobe to all banks, active high |
| sd_ref_cmd | output | 1 | One-cycle SDRAM refresh command |
| ref_done | output | 1 | One-cycle end-of-refresh pulse |

## Verification
The assertions assume that the configuration inputs and the grant are synchronous to `clk`. They assume the sequencer may assert the grant at any time, including when no request is pending, which the block must then ignore. The stimulus changes every input only on the falling edge. It keeps the intervals short, with count values near the top of the range, so that many expiries, merges and mid-run changes fit into one run; the single longest interval is exercised once. Grants are held off, held on or toggled at random, and enable is dropped both while a request is pending and while a refresh cycle is running.

// File: rtl/drc_pkg.sv
`timescale 1ns/1ps
package drc_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_SETUP   = 3'd1,
    SQ_STROBE  = 3'd2,
    SQ_CMD     = 3'd3,
    SQ_ROWBUSY = 3'd4,
    SQ_DONE    = 3'd5
  } sq_state_e;
endpackage

// File: rtl/drc_interval_timer.sv
`timescale 1ns/1ps
module drc_interval_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] count_val,
  input  logic             accept,
  output logic             req
);
  localparam int PW = CNT_W + 1;

  logic [PW-1:0] cnt_q, cnt_d, reload;
  logic          armed_q, armed_d;
  logic          req_q, req_d;

  // reload = interval - 1 = 2^CNT_W - count_val
  assign reload = PW'(1 << CNT_W) - {1'b0, count_val};

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    req_d   = req_q;
    if (!enable) begin
      cnt_d   = '0;
      armed_d = 1'b0;
      req_d   = 1'b0;
    end else if (!armed_q) begin
      armed_d = 1'b1;
      cnt_d   = reload;
      req_d   = req_q & ~accept;
    end else if (cnt_q == '0) begin
      cnt_d   = reload;
      req_d   = 1'b1;
    end else begin
      cnt_d   = cnt_q - 1'b1;
      req_d   = req_q & ~accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      req_q   <= req_d;
    end
  end

  assign req = req_q;

  // R10
  disable_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !req);

  // R2
  req_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($past(cnt_q) == '0 && $past(armed_q)));
endmodule

// File: rtl/drc_timing_decode.sv
`timescale 1ns/1ps
module drc_timing_decode #(
  parameter int HOLD_W        = 3,
  parameter int DRAM_HOLD_MAX = 4,
  parameter int SD_ROW_MAX    = 5
) (
  input  logic              sdram_mode,
  input  logic              setup_bit,
  input  logic [HOLD_W-1:0] hold_code,
  output logic [1:0]        setup_cyc,
  output logic [HOLD_W:0]   hold_cyc
);
  logic [HOLD_W-1:0] limit;
  logic [HOLD_W-1:0] code_c;

  assign limit     = sdram_mode ? HOLD_W'(SD_ROW_MAX) : HOLD_W'(DRAM_HOLD_MAX);
  assign code_c    = (hold_code > limit) ? limit : hold_code;
  assign hold_cyc  = {1'b0, code_c} + 1'b1;
  assign setup_cyc = (setup_bit && !sdram_mode) ? 2'd2 : 2'd1;
endmodule

// File: rtl/drc_cycle_seq.sv
`timescale 1ns/1ps
module drc_cycle_seq
  import drc_pkg::*;
#(
  parameter int HOLD_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sdram_mode,
  input  logic [1:0]      setup_cyc,
  input  logic [HOLD_W:0] hold_cyc,
  output logic            cas,
  output logic            ras,
  output logic            sd_cmd,
  output logic            done,
  output logic            idle
);
  localparam int RW = HOLD_W + 1;

  sq_state_e       state_q, state_d;
  logic [RW-1:0]   rem_q, rem_d;
  logic [RW-1:0]   hold_q;
  logic            hold_en;

  assign hold_en = start && (state_q == SQ_IDLE);

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    unique case (state_q)
      SQ_IDLE: if (start) begin
        if (sdram_mode) state_d = SQ_CMD;
        else begin
          state_d = SQ_SETUP;
          rem_d   = RW'(setup_cyc);
        end
      end
      SQ_SETUP: if (rem_q == RW'(1)) begin
        state_d = SQ_STROBE;
        rem_d   = hold_q;
      end else rem_d = rem_q - 1'b1;
      SQ_STROBE: if (rem_q == RW'(1)) state_d = SQ_DONE;
                 else rem_d = rem_q - 1'b1;
      SQ_CMD: begin
        state_d = SQ_ROWBUSY;
        rem_d   = hold_q;
      end
      SQ_ROWBUSY: if (rem_q == RW'(1)) state_d = SQ_DONE;
                  else rem_d = rem_q - 1'b1;
      SQ_DONE: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      rem_q   <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      if (hold_en) hold_q <= hold_cyc;
    end
  end

  assign cas    = (state_q == SQ_SETUP) || (state_q == SQ_STROBE);
  assign ras    = (state_q == SQ_STROBE);
  assign sd_cmd = (state_q == SQ_CMD);
  assign done   = (state_q == SQ_DONE);
  assign idle   = (state_q == SQ_IDLE);

  // R6
  ras_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras) |-> $past(cas));

  // R9
  cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cmd |=> !sd_cmd);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(ras) || $past(state_q == SQ_ROWBUSY)));
endmodule

// File: rtl/dram_refresh_ctl.sv
`timescale 1ns/1ps
module dram_refresh_ctl #(
  parameter int CNT_W         = 11,
  parameter int HOLD_W        = 3,
  parameter int DRAM_HOLD_MAX = 4,
  parameter int SD_ROW_MAX    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_setup,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic              cfg_sdram,
  input  logic              ref_grant,
  output logic              ref_req,
  output logic              ref_cas,
  output logic              ref_ras,
  output logic              sd_ref_cmd,
  output logic              ref_done
);
  logic            accept;
  logic            seq_idle;
  logic [1:0]      setup_cyc;
  logic [HOLD_W:0] hold_cyc;

  assign accept = ref_req && ref_grant && seq_idle;

  drc_interval_timer #(.CNT_W(CNT_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_enable),
    .count_val (cfg_count),
    .accept    (accept),
    .req       (ref_req)
  );

  drc_timing_decode #(
    .HOLD_W        (HOLD_W),
    .DRAM_HOLD_MAX (DRAM_HOLD_MAX),
    .SD_ROW_MAX    (SD_ROW_MAX)
  ) decode_i (
    .sdram_mode (cfg_sdram),
    .setup_bit  (cfg_setup),
    .hold_code  (cfg_hold),
    .setup_cyc  (setup_cyc),
    .hold_cyc   (hold_cyc)
  );

  drc_cycle_seq #(.HOLD_W(HOLD_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .sdram_mode (cfg_sdram),
    .setup_cyc  (setup_cyc),
    .hold_cyc   (hold_cyc),
    .cas        (ref_cas),
    .ras        (ref_ras),
    .sd_cmd     (sd_ref_cmd),
    .done       (ref_done),
    .idle       (seq_idle)
  );

  // R5
  start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_idle) |-> $past(ref_req && ref_grant));
endmodule

// File: tb/dram_refresh_ctl_tb.sv
`timescale 1ns/1ps
module dram_refresh_ctl_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        cfg_enable, cfg_setup, cfg_sdram, ref_grant;
  logic [10:0] cfg_count;
  logic [2:0]  cfg_hold;
  logic        ref_req, ref_cas, ref_ras, sd_ref_cmd, ref_done;

  dram_refresh_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_count(cfg_count),
    .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_sdram(cfg_sdram),
    .ref_grant(ref_grant), .ref_req(ref_req), .ref_cas(ref_cas),
    .ref_ras(ref_ras), .sd_ref_cmd(sd_ref_cmd), .ref_done(ref_done)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model: phase 0 idle, 1 setup, 2 strobe, 3 done, 4 cmd, 5 busy
  int m_cnt, m_ph, m_rem, m_hl;
  bit m_armed, m_req;

  always @(posedge clk or negedge rst_n) begin
    bit acc;
    int per;
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_rem = 0; m_hl = 0; m_armed = 0; m_req = 0;
    end else begin
      acc = m_req && ref_grant && (m_ph == 0);
      per = 2048 - int'(cfg_count) + 1;
      case (m_ph)
        0: if (acc) begin
             if (cfg_sdram) begin
               m_ph = 4; m_hl = ((cfg_hold > 5) ? 5 : int'(cfg_hold)) + 1;
             end else begin
               m_ph = 1; m_rem = cfg_setup ? 2 : 1;
               m_hl = ((cfg_hold > 4) ? 4 : int'(cfg_hold)) + 1;
             end
           end
        1: if (m_rem == 1) begin m_ph = 2; m_rem = m_hl; end else m_rem--;
        2: if (m_rem == 1) m_ph = 3; else m_rem--;
        3: m_ph = 0;
        4: begin m_ph = 5; m_rem = m_hl; end
        5: if (m_rem == 1) m_ph = 3; else m_rem--;
        default: m_ph = 0;
      endcase
      if (!cfg_enable) begin
        m_armed = 0; m_cnt = 0; m_req = 0;
      end else if (!m_armed) begin
        m_armed = 1; m_cnt = per - 1; m_req = m_req && !acc;
      end else if (m_cnt == 0) begin
        m_cnt = per - 1; m_req = 1;
      end else begin
        m_cnt--; m_req = m_req && !acc;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ref_req == m_req, "R2 R3 R4 ref_req", int'(ref_req), int'(m_req));
      chk(ref_cas == (m_ph == 1 || m_ph == 2), "R6 ref_cas", int'(ref_cas), int'(m_ph == 1 || m_ph == 2));
      chk(ref_ras == (m_ph == 2), "R7 ref_ras", int'(ref_ras), int'(m_ph == 2));
      chk(sd_ref_cmd == (m_ph == 4), "R9 sd_ref_cmd", int'(sd_ref_cmd), int'(m_ph == 4));
      chk(ref_done == (m_ph == 3), "R8 ref_done", int'(ref_done), int'(m_ph == 3));
    end
  end

  task automatic cfg(input bit en, input int cnt, input bit su, input int hd, input bit sd);
    cfg_enable = en; cfg_count = 11'(cnt); cfg_setup = su;
    cfg_hold = 3'(hd); cfg_sdram = sd;
  endtask

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    ref_grant = 1'b0;
    for (int i = 0; i < 20; i++) @(negedge clk);
  endtask

  // Wait for a signal to go high, counting negedges
  task automatic count_high(input int which, output int n);
    bit v;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      v = (which == 0) ? ref_ras : (which == 1) ? (ref_cas && !ref_ras) : ref_done;
      if (v) n++;
      else if (n > 0) break;
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0; ref_grant = 1'b0;
    cfg(0, 2040, 0, 0, 0);
    idle_wait(3);
    // R1 reset state
    chk(!ref_req && !ref_cas && !ref_ras && !sd_ref_cmd && !ref_done, "R1 reset outputs",
        int'({ref_req, ref_cas, ref_ras, sd_ref_cmd, ref_done}), 0);
    rst_n = 1'b1;
    idle_wait(2);

    // R2 first request after P+1 edges counting the enabling edge (P=9)
    cfg(1, 2040, 0, 0, 0);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!ref_req && n < 100);
    chk(n == 10, "R2 first request delay", n, 10);

    // R4 merged expiries served by one grant
    idle_wait(40);
    ref_grant = 1'b1; @(negedge clk); ref_grant = 1'b0;
    n = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (ref_done) n++; end
    chk(n == 1, "R4 single service for merged expiries", n, 1);

    // R10 disable drops pending request
    idle_wait(12);
    chk(ref_req == 1'b1, "R10 request pending before disable", int'(ref_req), 1);
    cfg_enable = 1'b0;
    @(negedge clk);
    chk(ref_req == 1'b0, "R10 request dropped", int'(ref_req), 0);

    // R1 / R5 disabled with grant held: no request, no strobes
    ref_grant = 1'b1;
    n = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (ref_req || ref_cas || sd_ref_cmd) n++; end
    chk(n == 0, "R1 R5 idle while disabled", n, 0);

    // R6 setup two cycles, R7 hold code 7 clamped to 5
    cfg(1, 2040, 1, 7, 0);
    count_high(1, n);
    chk(n == 2, "R6 CAS-only setup cycles", n, 2);
    cfg_enable = 1'b0; wait_idle();
    cfg(1, 2040, 1, 7, 0); ref_grant = 1'b1;
    count_high(0, n);
    chk(n == 5, "R7 clamped hold cycles", n, 5);
    cfg_enable = 1'b0; wait_idle();

    // R9 SDRAM code 7 clamped to 6 busy cycles; setup ignored
    cfg(1, 2040, 1, 7, 1); ref_grant = 1'b1;
    n = 0;
    for (int i = 0; i < 100 && !sd_ref_cmd; i++) @(negedge clk);
    for (int i = 0; i < 20; i++) begin @(negedge clk); n++; if (ref_done) break; end
    chk(n == 7, "R9 command to done cycles", n, 7);
    ref_grant = 1'b0;
    cfg_enable = 1'b0; wait_idle();

    // R8 hold code 2 in DRAM: done after 3 strobe cycles
    cfg(1, 2045, 0, 2, 0); ref_grant = 1'b1;
    count_high(0, n);
    chk(n == 3, "R8 R7 hold code 2", n, 3);
    @(negedge clk);
    chk(ref_done == 1'b0 && ref_cas == 1'b0, "R8 strobes low after done", int'({ref_done, ref_cas}), 0);

    // R3 count changed while running
    ref_grant = 1'b0;
    idle_wait(5);
    cfg_count = 11'd2030;
    idle_wait(60);
    ref_grant = 1'b1;
    idle_wait(60);

    // R10 disable during a running refresh: cycle completes (checked by model)
    ref_grant = 1'b0; cfg(1, 2046, 1, 4, 0);
    idle_wait(6);
    ref_grant = 1'b1; @(negedge clk); @(negedge clk); cfg_enable = 1'b0; ref_grant = 1'b0;
    idle_wait(15);

    // R2 longest interval, count value 0
    cfg(1, 0, 0, 0, 0);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!ref_req && n < 3000);
    chk(n == 2050, "R2 longest interval", n, 2050);
    cfg_enable = 1'b0; idle_wait(3);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      ref_grant = ($urandom % 3) != 0;
      if (($urandom % 150) == 0)
        cfg(($urandom % 8) != 0, 2030 + ($urandom % 18), 1'($urandom), $urandom % 8, 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule